// File: doc/BRIEF.md
# Enable-Gated On-Chip RAM Decoder

This block sits on a 24-bit CPU address bus with a 16-bit internal data path. It contains a small on-chip RAM and the decoder in front of it. Two separate address windows, 0xFFE000–0xFFEFBF and 0xFFFFC0–0xFFFFFF, can be served by the internal RAM. A single enable bit chooses the target. When the bit is set, accesses to these windows go to the RAM. When it is clear, they go to an external-bus request port. The address range 0xFFB000–0xFFDFFF is reserved: accesses there are trapped and are never performed.

The CPU side holds `req_i` together with the access attributes until `done_o` pulses. For internal accesses, `done_o` rises one clock after the request. For external accesses, it rises one clock after the external side answers on `ext_ack_i`. Both byte and word accesses are supported. Byte lanes are big-endian: the byte at the even address sits in the upper half of the word. Internally, the two RAM windows are packed into one contiguous word array.

Top module: `ramdec_top`

## Requirements
- R1: The RAM enable bit (`ram_en_o`) is 1 after reset. A write on `ctl_we_i` loads `ctl_wdata_i`, and the new value is visible and used from the following clock on.
- R2: With the enable bit at 1, any access to 0xFFE000–0xFFEFBF or 0xFFFFC0–0xFFFFFF is served by the internal RAM, and `ext_req_o` stays low.
- R3: Any access that is not trapped and not served internally is forwarded. `ext_req_o` is high combinationally with `req_i`, and `ext_addr_o`, `ext_we_o`, `ext_word_o` and `ext_wdata_o` equal the request. This covers the two windows when the enable bit is 0, and all other non-reserved addresses.
- R4: An internal RAM access, byte or word, read or write, completes in one clock. `done_o` is high in the cycle after the request is presented, and for a read `rdata_o` holds the data in that same cycle.
- R5: Byte lanes are big-endian. A byte at an even address uses bits [15:8] and a byte at an odd address uses bits [7:0]. A byte read returns the addressed byte on its lane, with the other lane at 0.
- R6: A byte write changes only the addressed lane. The other byte of the same RAM word keeps its value.
- R7: A word access with `addr_i[0]`=1 is not performed and not forwarded. `done_o` and `align_err_o` are high for one cycle and `rdata_o` is 0. This check takes priority over the reserved-window check.
- R8: An aligned access to 0xFFB000–0xFFDFFF, regardless of the enable bit, is not forwarded. A read returns 0 and a write is discarded. `done_o` and `acc_err_o` are high for one cycle.
- R9: Every word of both windows has its own storage. In particular, the last word of the lower window (0xFFEFBE) and the first word of the upper window (0xFFFFC0) do not alias.
- R10: A forwarded access completes one clock after `ext_ack_i` is sampled high. `done_o` is high then, and for a read `rdata_o` equals the `ext_rdata_i` value sampled with the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 1 | New value of the RAM enable bit |
| ram_en_o | output | 1 | Current RAM enable bit |
| req_i | input | 1 | Access request, held until done_o |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit word access, 0 = byte access |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data on big-endian lanes |
| rdata_o | output | 16 | Read data, valid with done_o |
| done_o | output | 1 | Access complete pulse |
| align_err_o | output | 1 | Odd-address word access pulse |
| acc_err_o | output | 1 | Reserved-window access pulse |
| ext_req_o | output | 1 | External bus request |
| ext_we_o | output | 1 | External write flag |
| ext_word_o | output | 1 | External word flag |
| ext_addr_o | output | 24 | External address |
| ext_wdata_o | output | 16 | External write data |
| ext_ack_i | input | 1 | External acknowledge |
| ext_rdata_i | input | 16 | External read data |

## Verification
The in-RTL assertions check the following on every cycle:
- the one-cycle latency of the enable bit;
- single-clock completion of internal accesses;
- the alignment trap, its priority, and its zero read data;
- the reserved-window trap and its zero read data;
- exclusivity of the two error pulses;
- completion of external accesses one clock after the acknowledge.

Some behaviour can only be shown by the bench's scenarios, which compare read data against a reference memory model: that byte writes preserve the neighbouring lane, that the two packed windows never alias, that trapped writes leave storage untouched, and that the routing decision follows enable changes made partway through traffic.

// File: rtl/ramdec_pkg.sv
package ramdec_pkg;
  typedef enum logic [1:0] {
    RT_EXT   = 2'd0,
    RT_RAM   = 2'd1,
    RT_ALIGN = 2'd2,
    RT_RSV   = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_EXT  = 2'd2
  } src_e;
endpackage

// File: rtl/ramdec_decode.sv
module ramdec_decode
  import ramdec_pkg::*;
#(
  parameter int                 ADDR_W = 24,
  parameter int                 IDX_W  = 11,
  parameter logic [ADDR_W-1:0]  A_LO   = 24'hFFE000,
  parameter logic [ADDR_W-1:0]  A_HI   = 24'hFFEFBF,
  parameter logic [ADDR_W-1:0]  B_LO   = 24'hFFFFC0,
  parameter logic [ADDR_W-1:0]  B_HI   = 24'hFFFFFF,
  parameter logic [ADDR_W-1:0]  R_LO   = 24'hFFB000,
  parameter logic [ADDR_W-1:0]  R_HI   = 24'hFFDFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  input  logic              ram_en_i,
  output route_e            route_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W:0] SPAN_A = {1'b0, A_HI} - {1'b0, A_LO} + 1'b1;
  localparam logic [ADDR_W:0] SPAN_B = {1'b0, B_HI} - {1'b0, B_LO} + 1'b1;
  localparam logic [ADDR_W:0] SPAN_R = {1'b0, R_HI} - {1'b0, R_LO} + 1'b1;
  localparam logic [IDX_W-1:0] A_WORDS = IDX_W'(SPAN_A >> 1);

  logic [ADDR_W-1:0] off_a, off_b, off_r;
  logic              in_a, in_b, in_r;

  // wrap-around offsets keep each window test a single compare
  assign off_a = addr_i - A_LO;
  assign off_b = addr_i - B_LO;
  assign off_r = addr_i - R_LO;
  assign in_a  = {1'b0, off_a} < SPAN_A;
  assign in_b  = {1'b0, off_b} < SPAN_B;
  assign in_r  = {1'b0, off_r} < SPAN_R;

  always_comb begin
    if (word_i && addr_i[0])            route_o = RT_ALIGN;
    else if (in_r)                      route_o = RT_RSV;
    else if (ram_en_i && (in_a || in_b)) route_o = RT_RAM;
    else                                route_o = RT_EXT;
  end

  // upper window packed directly after the lower one
  assign idx_o = in_a ? off_a[IDX_W:1] : A_WORDS + off_b[IDX_W:1];
endmodule

// File: rtl/ramdec_store.sv
module ramdec_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  parameter int IDX_W  = 11
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [1:0]        be_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) begin
        for (int l = 0; l < 2; l++) begin
          if (be_i[l]) mem_q[idx_i][l*HALF +: HALF] <= wdata_i[l*HALF +: HALF];
        end
      end
      rd_q <= mem_q[idx_i];
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/ramdec_resp.sv
module ramdec_resp
  import ramdec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  route_e            route_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic              lsb_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic              done_o,
  output logic              align_err_o,
  output logic              acc_err_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HALF = DATA_W / 2;

  logic              done_q, align_q, acc_q;
  src_e              src_q;
  logic [1:0]        mask_q;
  logic [DATA_W-1:0] ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      align_q <= 1'b0;
      acc_q   <= 1'b0;
      src_q   <= SRC_ZERO;
      mask_q  <= 2'b00;
      ext_q   <= '0;
    end else begin
      done_q  <= fire_i;
      align_q <= fire_i && (route_i == RT_ALIGN);
      acc_q   <= fire_i && (route_i == RT_RSV);
      if (fire_i) begin
        if (we_i)                  src_q <= SRC_ZERO;
        else if (route_i == RT_RAM) src_q <= SRC_RAM;
        else if (route_i == RT_EXT) src_q <= SRC_EXT;
        else                        src_q <= SRC_ZERO;
        mask_q <= word_i ? 2'b11 : (lsb_i ? 2'b01 : 2'b10);
        ext_q  <= ext_rdata_i;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_RAM: rdata_o = {ram_rdata_i[DATA_W-1:HALF] & {HALF{mask_q[1]}},
                          ram_rdata_i[HALF-1:0]      & {HALF{mask_q[0]}}};
      SRC_EXT: rdata_o = ext_q;
      default: rdata_o = '0;
    endcase
  end

  assign done_o      = done_q;
  assign align_err_o = align_q;
  assign acc_err_o   = acc_q;

  assert_err_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({align_err_o, acc_err_o}));
  assert_err_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_err_o || acc_err_o) |-> done_o);
endmodule

// File: rtl/ramdec_top.sv
module ramdec_top
  import ramdec_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_A_LO = 24'hFFE000,
  parameter logic [ADDR_W-1:0] WIN_A_HI = 24'hFFEFBF,
  parameter logic [ADDR_W-1:0] WIN_B_LO = 24'hFFFFC0,
  parameter logic [ADDR_W-1:0] WIN_B_HI = 24'hFFFFFF,
  parameter logic [ADDR_W-1:0] RSV_LO   = 24'hFFB000,
  parameter logic [ADDR_W-1:0] RSV_HI   = 24'hFFDFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              ctl_wdata_i,
  output logic              ram_en_o,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              align_err_o,
  output logic              acc_err_o,
  output logic              ext_req_o,
  output logic              ext_we_o,
  output logic              ext_word_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  input  logic              ext_ack_i,
  input  logic [DATA_W-1:0] ext_rdata_i
);
  localparam int DEPTH = (int'(WIN_A_HI - WIN_A_LO) + 1 + int'(WIN_B_HI - WIN_B_LO) + 1) / 2;
  localparam int IDX_W = $clog2(DEPTH);

  logic             en_q;
  route_e           route;
  logic [IDX_W-1:0] idx;
  logic             ram_go, fire;
  logic [1:0]       be;
  logic [DATA_W-1:0] ram_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b1;
    else if (ctl_we_i) en_q <= ctl_wdata_i;
  end
  assign ram_en_o = en_q;

  ramdec_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .A_LO(WIN_A_LO), .A_HI(WIN_A_HI),
    .B_LO(WIN_B_LO), .B_HI(WIN_B_HI),
    .R_LO(RSV_LO),   .R_HI(RSV_HI)
  ) u_decode (
    .addr_i   (addr_i),
    .word_i   (word_i),
    .ram_en_i (en_q),
    .route_o  (route),
    .idx_o    (idx)
  );

  assign ram_go = req_i && (route == RT_RAM);
  assign be     = word_i ? 2'b11 : (addr_i[0] ? 2'b01 : 2'b10);

  ramdec_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .en_i    (ram_go),
    .we_i    (we_i),
    .be_i    (be),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  assign ext_req_o   = req_i && (route == RT_EXT);
  assign ext_we_o    = we_i;
  assign ext_word_o  = word_i;
  assign ext_addr_o  = addr_i;
  assign ext_wdata_o = wdata_i;

  assign fire = req_i && ((route != RT_EXT) || ext_ack_i);

  ramdec_resp #(.DATA_W(DATA_W)) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .route_i     (route),
    .we_i        (we_i),
    .word_i      (word_i),
    .lsb_i       (addr_i[0]),
    .ram_rdata_i (ram_rdata),
    .ext_rdata_i (ext_rdata_i),
    .done_o      (done_o),
    .align_err_o (align_err_o),
    .acc_err_o   (acc_err_o),
    .rdata_o     (rdata_o)
  );

  assert_en_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (ram_en_o == $past(ctl_wdata_i)));
  assert_ram_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_go |=> done_o);
  assert_align_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && word_i && addr_i[0]) |=> (align_err_o && done_o && rdata_o == '0));
  assert_align_no_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> !(word_i && addr_i[0]));
  assert_rsv_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && route == RT_RSV) |=> (acc_err_o && rdata_o == '0));
  assert_ext_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && ext_ack_i && !we_i) |=> (done_o && rdata_o == $past(ext_rdata_i)));
endmodule

// File: tb/ramdec_top_tb_top.sv
module ramdec_top_tb_top;
  localparam logic [23:0] A_LO = 24'hFFE000, A_HI = 24'hFFEFBF;
  localparam logic [23:0] B_LO = 24'hFFFFC0, B_HI = 24'hFFFFFF;
  localparam logic [23:0] R_LO = 24'hFFB000, R_HI = 24'hFFDFFF;
  localparam int A_WORDS = 2016;
  localparam int DEPTH   = 2048;

  localparam int K_EXT = 0, K_RAM = 1, K_ALIGN = 2, K_RSV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, ctl_wdata = 1'b0;
  logic req = 1'b0, we = 1'b0, word = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ext_ack = 1'b0;
  logic [15:0] ext_rdata = '0;
  logic ram_en, done, align_err, acc_err, ext_req, ext_we, ext_word;
  logic [15:0] rdata, ext_wdata;
  logic [23:0] ext_addr;

  int errors = 0;
  int checks = 0;
  logic en_m = 1'b1;
  logic [15:0] mdl [DEPTH];

  always #2 clk = ~clk;

  ramdec_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ram_en_o(ram_en),
    .req_i(req), .we_i(we), .word_i(word), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .done_o(done), .align_err_o(align_err), .acc_err_o(acc_err),
    .ext_req_o(ext_req), .ext_we_o(ext_we), .ext_word_o(ext_word),
    .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata),
    .ext_ack_i(ext_ack), .ext_rdata_i(ext_rdata)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic in_rng(input logic [23:0] a, input logic [23:0] lo, input logic [23:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic int classify(input logic [23:0] a, input logic w, input logic en);
    if (w && a[0]) return K_ALIGN;
    if (in_rng(a, R_LO, R_HI)) return K_RSV;
    if (en && (in_rng(a, A_LO, A_HI) || in_rng(a, B_LO, B_HI))) return K_RAM;
    return K_EXT;
  endfunction

  function automatic int widx(input logic [23:0] a);
    if (in_rng(a, A_LO, A_HI)) return int'((a - A_LO) >> 1);
    return A_WORDS + int'((a - B_LO) >> 1);
  endfunction

  function automatic logic [23:0] idx_addr(input int i);
    if (i < A_WORDS) return A_LO + 24'(2 * i);
    return B_LO + 24'(2 * (i - A_WORDS));
  endfunction

  task automatic set_en(input logic v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    en_m = v;
    chk(ram_en == v, "R1 enable load", 32'(ram_en), 32'(v));
  endtask

  task automatic access(input logic w_e, input logic w_d, input logic [23:0] a,
                        input logic [15:0] wd, input int dly);
    int k;
    logic [15:0] exp_rd, er;
    k = classify(a, w_d, en_m);
    req = 1'b1; we = w_e; word = w_d; addr = a; wdata = wd;
    er = 16'($urandom);
    #1;
    chk(ext_req == (k == K_EXT), "R3 ext_req routing", 32'(ext_req), 32'(k == K_EXT));
    if (k == K_EXT) begin
      chk(ext_addr == a && ext_we == w_e && ext_word == w_d && ext_wdata == wd,
          "R3 ext fields", 32'(ext_addr), 32'(a));
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk(!done, "R10 no done before ack", 32'(done), 32'd0);
      end
      ext_ack = 1'b1; ext_rdata = er;
    end
    @(negedge clk);
    ext_ack = 1'b0;
    exp_rd = 16'h0000;
    if (!w_e && k == K_RAM) begin
      exp_rd = mdl[widx(a)];
      if (!w_d) exp_rd = a[0] ? {8'h00, exp_rd[7:0]} : {exp_rd[15:8], 8'h00};
    end else if (!w_e && k == K_EXT) begin
      exp_rd = er;
    end
    chk(done, "R4 done after access", 32'(done), 32'd1);
    chk(rdata == exp_rd, (k == K_EXT) ? "R10 ext read data" :
        (w_d ? "R4 word read data" : "R5 byte lane read data"), 32'(rdata), 32'(exp_rd));
    chk(align_err == (k == K_ALIGN), "R7 align pulse", 32'(align_err), 32'(k == K_ALIGN));
    chk(acc_err == (k == K_RSV), "R8 reserved pulse", 32'(acc_err), 32'(k == K_RSV));
    if (w_e && k == K_RAM) begin
      if (w_d)       mdl[widx(a)] = wd;
      else if (a[0]) mdl[widx(a)][7:0]  = wd[7:0];
      else           mdl[widx(a)][15:8] = wd[15:8];
    end
    req = 1'b0; we = 1'b0; word = 1'b0;
  endtask

  function automatic logic [23:0] rand_addr();
    logic [31:0] r;
    r = $urandom % 6;
    case (r)
      0, 1: return A_LO + 24'($urandom % 4032);
      2:    return B_LO + 24'($urandom % 64);
      3:    return R_LO + 24'($urandom % 24'h3000);
      default: return 24'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(ram_en == 1'b1, "R1 enable after reset", 32'(ram_en), 32'd1);
    chk(!done && !align_err && !acc_err && !ext_req, "R4 idle outputs in reset",
        {28'd0, done, align_err, acc_err, ext_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ram_en == 1'b1, "R1 enable after release", 32'(ram_en), 32'd1);

    // preload every RAM word (R2)
    for (int i = 0; i < DEPTH; i++) access(1'b1, 1'b1, idx_addr(i), 16'($urandom), 0);

    // R9 window boundary words do not alias
    access(1'b1, 1'b1, 24'hFFEFBE, 16'hA1B2, 0);
    access(1'b1, 1'b1, 24'hFFFFC0, 16'hC3D4, 0);
    access(1'b0, 1'b1, 24'hFFEFBE, 16'h0, 0);
    chk(rdata == 16'hA1B2, "R9 lower window last word", 32'(rdata), 32'hA1B2);
    access(1'b0, 1'b1, 24'hFFFFC0, 16'h0, 0);
    chk(rdata == 16'hC3D4, "R9 upper window first word", 32'(rdata), 32'hC3D4);

    // R6 byte write keeps the other lane; R5 lane placement
    access(1'b1, 1'b1, 24'hFFE010, 16'h1234, 0);
    access(1'b1, 1'b0, 24'hFFE010, 16'hAB00, 0);
    access(1'b1, 1'b0, 24'hFFE011, 16'h00CD, 0);
    access(1'b0, 1'b1, 24'hFFE010, 16'h0, 0);
    chk(rdata == 16'hABCD, "R6 byte writes merge", 32'(rdata), 32'hABCD);
    access(1'b1, 1'b0, 24'hFFFFFF, 16'h0077, 0);
    access(1'b0, 1'b0, 24'hFFFFFF, 16'h0, 0);
    chk(rdata == 16'h0077, "R5 odd byte low lane", 32'(rdata), 32'h0077);

    // R7 odd word in RAM window and in reserved window (priority)
    access(1'b1, 1'b1, 24'hFFE011, 16'hFFFF, 0);
    access(1'b0, 1'b1, 24'hFFE010, 16'h0, 0);
    chk(rdata == 16'hABCD, "R7 odd word write not performed", 32'(rdata), 32'hABCD);
    access(1'b0, 1'b1, 24'hFFC001, 16'h0, 0);

    // R8 reserved read/write, with enable set and clear
    access(1'b1, 1'b1, 24'hFFB000, 16'h5555, 0);
    access(1'b0, 1'b0, 24'hFFDFFF, 16'h0, 0);

    // R3 enable cleared: windows forwarded, RAM untouched
    set_en(1'b0);
    access(1'b1, 1'b1, 24'hFFE010, 16'h9999, 1);
    access(1'b0, 1'b1, 24'hFFFFC0, 16'h0, 2);
    access(1'b0, 1'b1, 24'hFFD000, 16'h0, 0);
    access(1'b0, 1'b1, 24'h001234, 16'h0, 0);
    set_en(1'b1);
    access(1'b0, 1'b1, 24'hFFE010, 16'h0, 0);
    chk(rdata == 16'hABCD, "R3 forwarded write left RAM intact", 32'(rdata), 32'hABCD);

    // random traffic (R2 R3 R4 R5 R6 R7 R8 R10)
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 50) == 0) set_en(1'($urandom));
      access(1'($urandom), 1'($urandom), rand_addr(), 16'($urandom), int'($urandom % 3));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule